// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the 13-bit instruction address of a small 8-bit microcontroller core whose program memory is split into pages. The low eight bits form a byte that software reads and writes as an ordinary data register. The five upper bits cannot be read directly. They are filled from a separate 5-bit page latch that software loads ahead of time. The latch itself sits inside this block.

Each cycle the decode logic raises at most a few event strobes. The unit picks one of them by a fixed priority and forms the next address from the matching source:
- a fixed interrupt vector;
- a full 13-bit return address popped from the return stack;
- an 11-bit jump/call immediate joined to two latch bits;
- a data write to the low byte joined to all five latch bits;
- a plain increment.

Writing the low byte is how computed jumps work. Only the byte is written, so a table jump wraps inside its 256-word block. Instruction fetch, the ALU and the stack storage are outside the block.

Top module: `pc_paged_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and latch_o is 0.
- R2: With no event strobe, the counter adds 1 modulo 8192 when adv_i is 1 (0x1FFF becomes 0x0000), and holds when adv_i is 0.
- R3: low_we_i loads the counter with {latch_o[4:0], low_wdata_i[7:0]}. The upper bits come only from the latch, so a computed jump whose byte sum carries out of bit 7 stays in the current 256-word block.
- R4: jump_i loads the counter with {latch_o[4:3], imm_i[10:0]}.
- R5: ret_i loads the counter with the full ret_addr_i[12:0], whatever the latch holds.
- R6: vec_i loads the counter with VEC_ADDR (default 13'h0004).
- R7: When several strobes are high, the winner is chosen in this order: vec_i, then ret_i, then jump_i, then low_we_i, then increment or hold.
- R8: latch_o takes latch_wdata_i on an edge where latch_we_i is 1. Otherwise it keeps its value, including across return, jump, vector and low-byte events.
- R9: When latch_we_i arrives in the same cycle as low_we_i or jump_i, the counter uses the latch value from before the write.
- R10: pcl_o always equals pc_o[7:0].
- R11: Every counter and latch update appears on the first rising clock edge after the strobes are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance by one when no event is present |
| low_we_i | input | 1 | Write to the low byte |
| low_wdata_i | input | 8 | Low-byte write data |
| jump_i | input | 1 | Jump or call |
| imm_i | input | 11 | Jump/call target field |
| ret_i | input | 1 | Return from call or interrupt |
| ret_addr_i | input | 13 | Popped return address |
| vec_i | input | 1 | Interrupt vector load |
| latch_we_i | input | 1 | Page latch write |
| latch_wdata_i | input | 5 | Page latch write data |
| pc_o | output | 13 | Current program counter |
| pcl_o | output | 8 | Readable low byte |
| latch_o | output | 5 | Page latch value |

## Verification
Every result is due on the single rising edge that follows the cycle in which the strobes are presented. The same holds for the latch update and for the counter value built from the old latch. The driver applies each stimulus on the falling edge and queues the expected counter, low byte and latch at that moment. The monitor compares them 1 ns after the next rising edge, so each queued item is matched to exactly the one edge that should produce it.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int PC_W    = 13;
  localparam int PCL_W   = 8;
  localparam int IMM_W   = 11;
  localparam int LATCH_W = PC_W - PCL_W;
  localparam int PAGE_W  = PC_W - IMM_W;

  typedef enum logic [2:0] {
    EV_HOLD,
    EV_INC,
    EV_LOW,
    EV_JUMP,
    EV_RET,
    EV_VEC
  } pc_ev_e;
endpackage

// File: rtl/pc_event_sel.sv
module pc_event_sel
  import pc_pkg::*;
(
  input  logic   adv_i,
  input  logic   low_we_i,
  input  logic   jump_i,
  input  logic   ret_i,
  input  logic   vec_i,
  output pc_ev_e ev_o
);
  always_comb begin
    if (vec_i)         ev_o = EV_VEC;
    else if (ret_i)    ev_o = EV_RET;
    else if (jump_i)   ev_o = EV_JUMP;
    else if (low_we_i) ev_o = EV_LOW;
    else if (adv_i)    ev_o = EV_INC;
    else               ev_o = EV_HOLD;
  end
endmodule

// File: rtl/pc_latch_reg.sv
module pc_latch_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_pkg::*;
#(
  parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
  input  pc_ev_e             ev_i,
  input  logic [PC_W-1:0]    pc_q_i,
  input  logic [LATCH_W-1:0] latch_i,
  input  logic [PCL_W-1:0]   low_wdata_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [PC_W-1:0]    ret_addr_i,
  output logic [PC_W-1:0]    pc_d_o
);
  localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic [PAGE_W-1:0] page_sel;
  // page bits are the top bits of the latch
  assign page_sel = latch_i[LATCH_W-1 -: PAGE_W];

  always_comb begin
    unique case (ev_i)
      EV_VEC:  pc_d_o = VEC_ADDR;
      EV_RET:  pc_d_o = ret_addr_i;
      EV_JUMP: pc_d_o = {page_sel, imm_i};
      EV_LOW:  pc_d_o = {latch_i, low_wdata_i};
      EV_INC:  pc_d_o = pc_q_i + ONE;
      default: pc_d_o = pc_q_i;
    endcase
  end
endmodule

// File: rtl/pc_paged_unit.sv
module pc_paged_unit
  import pc_pkg::*;
#(
  parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic               low_we_i,
  input  logic [PCL_W-1:0]   low_wdata_i,
  input  logic               jump_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic               ret_i,
  input  logic [PC_W-1:0]    ret_addr_i,
  input  logic               vec_i,
  input  logic               latch_we_i,
  input  logic [LATCH_W-1:0] latch_wdata_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PCL_W-1:0]   pcl_o,
  output logic [LATCH_W-1:0] latch_o
);
  pc_ev_e          ev;
  logic [PC_W-1:0] pc_q, pc_d;

  pc_event_sel i_sel (
    .adv_i    (adv_i),
    .low_we_i (low_we_i),
    .jump_i   (jump_i),
    .ret_i    (ret_i),
    .vec_i    (vec_i),
    .ev_o     (ev)
  );

  pc_latch_reg #(.W(LATCH_W)) i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (latch_we_i),
    .wdata_i (latch_wdata_i),
    .q_o     (latch_o)
  );

  pc_next_calc #(.VEC_ADDR(VEC_ADDR)) i_next (
    .ev_i        (ev),
    .pc_q_i      (pc_q),
    .latch_i     (latch_o),
    .low_wdata_i (low_wdata_i),
    .imm_i       (imm_i),
    .ret_addr_i  (ret_addr_i),
    .pc_d_o      (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o  = pc_q;
  assign pcl_o = pc_q[PCL_W-1:0];
endmodule

// File: rtl/pc_paged_unit_chk.sv
module pc_paged_unit_chk
  import pc_pkg::*;
#(
  parameter logic [PC_W-1:0] VEC_ADDR = 13'h0004
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               adv_i,
  input logic               low_we_i,
  input logic [PCL_W-1:0]   low_wdata_i,
  input logic               jump_i,
  input logic [IMM_W-1:0]   imm_i,
  input logic               ret_i,
  input logic [PC_W-1:0]    ret_addr_i,
  input logic               vec_i,
  input logic               latch_we_i,
  input logic [LATCH_W-1:0] latch_wdata_i,
  input logic [PC_W-1:0]    pc_o,
  input logic [PCL_W-1:0]   pcl_o,
  input logic [LATCH_W-1:0] latch_o
);
  logic no_ev;
  assign no_ev = !vec_i && !ret_i && !jump_i && !low_we_i;

  always_comb begin
    if (!rst_ni) p_reset_r1: assert (pc_o == '0 && latch_o == '0);
  end

  p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_ev && adv_i |=> pc_o == PC_W'($past(pc_o) + 1'b1));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_ev && !adv_i |=> $stable(pc_o));
  // R9: the old latch value is used
  p_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_i && !ret_i && !jump_i && low_we_i |=>
      pc_o == {$past(latch_o), $past(low_wdata_i)});
  p_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_i && !ret_i && jump_i |=>
      pc_o == {$past(latch_o[LATCH_W-1 -: PAGE_W]), $past(imm_i)});
  p_ret_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_i && ret_i |=> pc_o == $past(ret_addr_i));
  p_vec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_i |=> pc_o == VEC_ADDR);
  p_latch_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_we_i |=> $stable(latch_o));
  p_latch_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_we_i |=> latch_o == $past(latch_wdata_i));
  p_pcl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcl_o == pc_o[PCL_W-1:0]);
endmodule

bind pc_paged_unit pc_paged_unit_chk #(.VEC_ADDR(VEC_ADDR)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .adv_i         (adv_i),
  .low_we_i      (low_we_i),
  .low_wdata_i   (low_wdata_i),
  .jump_i        (jump_i),
  .imm_i         (imm_i),
  .ret_i         (ret_i),
  .ret_addr_i    (ret_addr_i),
  .vec_i         (vec_i),
  .latch_we_i    (latch_we_i),
  .latch_wdata_i (latch_wdata_i),
  .pc_o          (pc_o),
  .pcl_o         (pcl_o),
  .latch_o       (latch_o)
);

// File: tb/test_pc_paged_unit.sv
`timescale 1ns/1ps
module test_pc_paged_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        adv = 0, low_we = 0, jump = 0, ret = 0, vec = 0, latch_we = 0;
  logic [7:0]  low_wdata = 0;
  logic [10:0] imm = 0;
  logic [12:0] ret_addr = 0;
  logic [4:0]  latch_wdata = 0;
  logic [12:0] pc;
  logic [7:0]  pcl;
  logic [4:0]  latch;

  typedef struct {
    logic [12:0] pc;
    logic [4:0]  latch;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_fail = 0;
  logic [12:0] m_pc = 0;
  logic [4:0]  m_latch = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  pc_paged_unit i_pc_paged_unit (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .low_we_i(low_we),
    .low_wdata_i(low_wdata), .jump_i(jump), .imm_i(imm), .ret_i(ret),
    .ret_addr_i(ret_addr), .vec_i(vec), .latch_we_i(latch_we),
    .latch_wdata_i(latch_wdata), .pc_o(pc), .pcl_o(pcl), .latch_o(latch)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply at falling edge, model the requirements, queue the result
  task automatic step(string tag, bit v, bit r, bit j, bit lw, bit a, bit lwe,
                      logic [4:0] ld, logic [7:0] wd, logic [10:0] im,
                      logic [12:0] ra);
    exp_t e;
    @(negedge clk);
    vec = v; ret = r; jump = j; low_we = lw; adv = a; latch_we = lwe;
    latch_wdata = ld; low_wdata = wd; imm = im; ret_addr = ra;
    if (v)       m_pc = 13'h0004;              // R6
    else if (r)  m_pc = ra;                    // R5
    else if (j)  m_pc = {m_latch[4:3], im};    // R4, old latch R9
    else if (lw) m_pc = {m_latch, wd};         // R3, old latch R9
    else if (a)  m_pc = m_pc + 13'd1;          // R2
    if (lwe) m_latch = ld;                     // R8
    e.pc = m_pc; e.latch = m_latch; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: each queued item is due on the next rising edge (R11)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " pc R11"}, 32'(pc), 32'(e.pc));
        check({e.tag, " latch"}, 32'(latch), 32'(e.latch));
        check("R10 pcl", 32'(pcl), 32'(e.pc[7:0]));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pc", 32'(pc), 0);
    check("R1 latch", 32'(latch), 0);
    rst_n = 1;
    step("R2 inc", 0,0,0,0,1,0, 0,0,0,0);
    step("R2 inc", 0,0,0,0,1,0, 0,0,0,0);
    step("R2 hold", 0,0,0,0,0,0, 0,0,0,0);
    step("R8 latch wr", 0,0,0,0,1,1, 5'h0A,0,0,0);
    step("R3 low wr", 0,0,0,1,1,0, 0,8'hF0,0,0);
    step("R3 wrap", 0,0,0,1,0,0, 0,8'h10,0,0);  // F0+20 carries, stays in block
    step("R4 jump", 0,0,1,0,1,0, 0,0,11'h123,0);
    step("R8 latch wr", 0,0,0,0,0,1, 5'h1F,0,0,0);
    step("R4 jump top", 0,0,1,0,0,0, 0,0,11'h7FF,0);
    step("R2 wrap", 0,0,0,0,1,0, 0,0,0,0);
    step("R5 ret", 0,1,0,0,1,0, 0,0,0,13'h1555);
    step("R8 keep ret", 0,1,0,0,0,0, 0,0,0,13'h0ABC);
    step("R7 vec wins", 1,1,1,1,1,0, 0,8'h55,11'h111,13'h1234);
    step("R7 ret over jump", 0,1,1,1,1,0, 0,8'h55,11'h111,13'h1234);
    step("R7 jump over low", 0,0,1,1,1,0, 0,8'h55,11'h222,0);
    step("R7 low over inc", 0,0,0,1,1,0, 0,8'h66,0,0);
    step("R9 low+latch", 0,0,0,1,0,1, 5'h02,8'h33,0,0);
    step("R9 jump+latch", 0,0,1,0,0,1, 5'h08,0,11'h400,0);
    step("R6 vec", 1,0,0,0,0,0, 0,0,0,0);
    step("R2 hold end", 0,0,0,0,0,0, 0,0,0,0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule